// File: doc/BRIEF.md
# Out-of-Order Dispatch Queue

The queue sits between instruction decode and the execution units of an out-of-order core. Decode writes one instruction per cycle into a free slot. Each slot records two source tags with their ready bits, a destination tag, the unit class the instruction needs, a load flag and an age counter. Result tags broadcast by the execution units wake up waiting sources.

Every cycle, each unit class picks at most one slot whose two sources are ready. Loads win over non-loads, and older entries win over younger ones. A grant also needs two more things: the unit must be able to accept an operation, and a rename register must be free for the result. Program order plays no part beyond the age counter.

Unpipelined unit classes, such as a divider, are marked busy from their dispatch until the unit reports completion. A flush empties the queue in one cycle.

Top module: `ooo_issue_queue`

## Requirements
- R1: A slot is eligible only when both source ready bits are set. A ready bit comes from the enqueue flag or from a matching valid wake tag. A wake tag seen in cycle t, or a slot enqueued in cycle t, can be dispatched at the earliest in cycle t+1. A wake tag that matches a source being enqueued in the same cycle sets that ready bit.
- R2: Each class c (0 to 3, the 2-bit class field) gets at most one grant per cycle, and only while `unit_ready[c]` is high and the class is not busy. The granted slot is removed at the next clock edge. For a class without a grant, `dsp_dst` and `dsp_slot` read zero.
- R3: The number of grants in a cycle never exceeds `preg_avail`. When registers run short, lower class numbers are served first.
- R4: Among eligible slots of one class, a slot with the load flag set is chosen over one without it, whatever the ages.
- R5: Within the same load kind, the larger age wins. Age is 0 on enqueue and rises by 1 each cycle up to 7, where it saturates. When ages are equal, the lowest slot index wins.
- R6: A younger eligible slot dispatches while an older slot of the same class is still waiting for operands.
- R7: A class whose `PIPE_MASK` bit is 0 (by default only class 3) is busy from the cycle after its dispatch until a `unit_done` pulse for it. Its next dispatch can come at the earliest in the cycle after that pulse. Pipelined classes can dispatch every cycle.
- R8: `full` is high exactly when all 8 slots hold entries. An enqueue while `full` is high is dropped. An accepted entry goes to the lowest free slot.
- R9: A flush removes every entry at the next edge. An enqueue in the flush cycle is dropped. In the cycle after a flush there is no dispatch and `full` is low.
- R10: After reset the queue is empty, `full` is low, no class is busy and no dispatch is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Clear all entries |
| enq_valid | input | 1 | Enqueue request |
| enq_src0 | input | 6 | First source tag |
| enq_rdy0 | input | 1 | First source already available |
| enq_src1 | input | 6 | Second source tag |
| enq_rdy1 | input | 1 | Second source already available |
| enq_dst | input | 6 | Destination tag |
| enq_cls | input | 2 | Required unit class |
| enq_load | input | 1 | Instruction is a load |
| full | output | 1 | All slots occupied |
| wk_valid | input | 2 | Wake broadcast valid, one bit per lane |
| wk_tag | input | 12 | Wake tags, lane k in bits k*6 +: 6 |
| unit_ready | input | 4 | Unit of class c can accept this cycle |
| unit_done | input | 4 | Unpipelined unit of class c finishes |
| preg_avail | input | 3 | Free rename registers this cycle |
| dsp_valid | output | 4 | Grant for class c |
| dsp_dst | output | 24 | Destination tag of grant c in bits c*6 +: 6 |
| dsp_slot | output | 12 | Slot index of grant c in bits c*3 +: 3 |

## Verification
Grants are combinational from the stored state and the current `unit_ready`, `preg_avail` and busy state. They are therefore due in the same cycle the inputs are driven. The effect of an enqueue, a wake tag, a dispatch, a `unit_done` pulse or a flush shows up one edge later.

The bench drives inputs on the falling edge and compares outputs a moment later. Only then does it advance its reference state, which applies exactly the one-edge rules above. Directed sequences count cycles explicitly around each wake, busy window, register shortage, full queue and flush.

// File: rtl/ooo_issue_queue.sv
module ooo_issue_queue #(
  parameter int DEPTH  = 8,
  parameter int TAGW   = 6,
  parameter int AGEW   = 3,
  parameter int NCLS   = 4,
  parameter int WAKE_N = 2,
  parameter logic [NCLS-1:0] PIPE_MASK = 4'b0111,
  localparam int SLOTW = $clog2(DEPTH),
  localparam int CLSW  = $clog2(NCLS),
  localparam int CNTW  = $clog2(NCLS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     enq_valid,
  input  logic [TAGW-1:0]          enq_src0,
  input  logic                     enq_rdy0,
  input  logic [TAGW-1:0]          enq_src1,
  input  logic                     enq_rdy1,
  input  logic [TAGW-1:0]          enq_dst,
  input  logic [CLSW-1:0]          enq_cls,
  input  logic                     enq_load,
  output logic                     full,
  input  logic [WAKE_N-1:0]        wk_valid,
  input  logic [WAKE_N*TAGW-1:0]   wk_tag,
  input  logic [NCLS-1:0]          unit_ready,
  input  logic [NCLS-1:0]          unit_done,
  input  logic [CNTW-1:0]          preg_avail,
  output logic [NCLS-1:0]          dsp_valid,
  output logic [NCLS*TAGW-1:0]     dsp_dst,
  output logic [NCLS*SLOTW-1:0]    dsp_slot
);
  localparam logic [AGEW-1:0] AGE_MAX = '1;

  logic [DEPTH-1:0] v, r0, r1, ld, taken, hit0, hit1;
  logic [TAGW-1:0]  s0 [DEPTH];
  logic [TAGW-1:0]  s1 [DEPTH];
  logic [TAGW-1:0]  dst [DEPTH];
  logic [CLSW-1:0]  cls [DEPTH];
  logic [AGEW-1:0]  age [DEPTH];
  logic [NCLS-1:0]  busy;
  logic [SLOTW-1:0] free_idx;
  logic             enq_go, ehit0, ehit1;

  function automatic logic woke(input logic [TAGW-1:0] t);
    logic m;
    m = 1'b0;
    for (int k = 0; k < WAKE_N; k++)
      if (wk_valid[k] && wk_tag[k*TAGW +: TAGW] == t) m = 1'b1;
    return m;
  endfunction

  assign full   = &v;
  assign enq_go = enq_valid && !full && !flush;
  assign ehit0  = woke(enq_src0);
  assign ehit1  = woke(enq_src1);

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!v[i]) free_idx = SLOTW'(i);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit0[i] = woke(s0[i]);
      hit1[i] = woke(s1[i]);
    end
  end

  always_comb begin
    logic [CNTW-1:0]  ngr;
    logic [SLOTW-1:0] bi;
    logic             bok;
    ngr       = '0;
    taken     = '0;
    dsp_valid = '0;
    dsp_dst   = '0;
    dsp_slot  = '0;
    for (int c = 0; c < NCLS; c++) begin
      bok = 1'b0;
      bi  = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (v[i] && r0[i] && r1[i] && cls[i] == CLSW'(c)) begin
          if (!bok || (ld[i] && !ld[bi]) || (ld[i] == ld[bi] && age[i] > age[bi])) begin
            bok = 1'b1;
            bi  = SLOTW'(i);
          end
        end
      end
      if (bok && unit_ready[c] && !busy[c] && ngr < preg_avail) begin
        dsp_valid[c]                 = 1'b1;
        dsp_dst[c*TAGW +: TAGW]      = dst[bi];
        dsp_slot[c*SLOTW +: SLOTW]   = bi;
        taken[bi]                    = 1'b1;
        ngr                          = ngr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
    end else begin
      busy <= (busy & ~unit_done) | (dsp_valid & ~PIPE_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v  <= '0;
      r0 <= '0;
      r1 <= '0;
      ld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        s0[i]  <= '0;
        s1[i]  <= '0;
        dst[i] <= '0;
        cls[i] <= '0;
        age[i] <= '0;
      end
    end else if (flush) begin
      v <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (taken[i]) begin
          v[i] <= 1'b0;
        end else if (v[i]) begin
          r0[i]  <= r0[i] | hit0[i];
          r1[i]  <= r1[i] | hit1[i];
          age[i] <= (age[i] == AGE_MAX) ? AGE_MAX : age[i] + 1'b1;
        end
      end
      if (enq_go) begin
        v[free_idx]   <= 1'b1;
        s0[free_idx]  <= enq_src0;
        s1[free_idx]  <= enq_src1;
        r0[free_idx]  <= enq_rdy0 | ehit0;
        r1[free_idx]  <= enq_rdy1 | ehit1;
        dst[free_idx] <= enq_dst;
        cls[free_idx] <= enq_cls;
        ld[free_idx]  <= enq_load;
        age[free_idx] <= '0;
      end
    end
  end
endmodule

// File: rtl/ooo_issue_queue_chk.sv
module ooo_issue_queue_chk #(
  parameter int NCLS = 4,
  parameter int CNTW = 3,
  parameter logic [NCLS-1:0] PIPE_MASK = 4'b0111
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            full,
  input logic [NCLS-1:0] unit_ready,
  input logic [NCLS-1:0] unit_done,
  input logic [NCLS-1:0] dsp_valid,
  input logic [CNTW-1:0] preg_avail
);
  logic [NCLS-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= (held & ~unit_done) | (dsp_valid & ~PIPE_MASK);
  end

  // R3
  preg_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dsp_valid) <= int'(preg_avail));

  // R2
  unit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid & ~unit_ready) == '0);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (dsp_valid == '0 && !full));

  for (genvar c = 0; c < NCLS; c++) begin : g_np
    if (!PIPE_MASK[c]) begin : g_on
      // R7
      unpiped_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held[c] |-> !dsp_valid[c]);
      // R7
      unpiped_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid[c] |=> !dsp_valid[c]);
    end
  end
endmodule

bind ooo_issue_queue ooo_issue_queue_chk #(
  .NCLS(NCLS), .CNTW(CNTW), .PIPE_MASK(PIPE_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .full(full),
  .unit_ready(unit_ready), .unit_done(unit_done),
  .dsp_valid(dsp_valid), .preg_avail(preg_avail)
);

// File: tb/sim_ooo_issue_queue.sv
`timescale 1ns/1ps
module sim_ooo_issue_queue;
  localparam int D = 8, TW = 6, NC = 4, WN = 2, SW = 3, CW = 3;
  localparam logic [NC-1:0] PM = 4'b0111;

  logic clk = 0, rst_n = 0, flush = 0;
  logic enq_valid = 0, enq_rdy0 = 0, enq_rdy1 = 0, enq_load = 0;
  logic [TW-1:0] enq_src0 = 0, enq_src1 = 0, enq_dst = 0;
  logic [1:0] enq_cls = 0;
  logic full;
  logic [WN-1:0] wk_valid = 0;
  logic [WN*TW-1:0] wk_tag = 0;
  logic [NC-1:0] unit_ready = '1, unit_done = 0;
  logic [CW-1:0] preg_avail = 3'd4;
  logic [NC-1:0] dsp_valid;
  logic [NC*TW-1:0] dsp_dst;
  logic [NC*SW-1:0] dsp_slot;

  ooo_issue_queue u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .enq_valid(enq_valid),
    .enq_src0(enq_src0), .enq_rdy0(enq_rdy0), .enq_src1(enq_src1), .enq_rdy1(enq_rdy1),
    .enq_dst(enq_dst), .enq_cls(enq_cls), .enq_load(enq_load), .full(full),
    .wk_valid(wk_valid), .wk_tag(wk_tag), .unit_ready(unit_ready), .unit_done(unit_done),
    .preg_avail(preg_avail), .dsp_valid(dsp_valid), .dsp_dst(dsp_dst), .dsp_slot(dsp_slot));

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  bit mv[D], mr0[D], mr1[D], mld[D];
  logic [TW-1:0] ms0[D], ms1[D], mdst[D];
  int mcls[D], mage[D];
  logic [NC-1:0] mbusy = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit mwoke(logic [TW-1:0] t);
    for (int k = 0; k < WN; k++)
      if (wk_valid[k] && wk_tag[k*TW +: TW] == t) return 1;
    return 0;
  endfunction

  task automatic cyc(string tag);
    logic [NC-1:0] ev;
    logic [NC*TW-1:0] ed;
    logic [NC*SW-1:0] es;
    bit tk[D];
    bit efull, go;
    int ngr, fi;
    #1;
    ev = 0; ed = 0; es = 0; ngr = 0; efull = 1;
    for (int i = 0; i < D; i++) begin tk[i] = 0; if (!mv[i]) efull = 0; end
    for (int c = 0; c < NC; c++) begin
      int b;
      b = -1;
      for (int i = 0; i < D; i++)
        if (mv[i] && mr0[i] && mr1[i] && mcls[i] == c)
          if (b < 0 || (mld[i] && !mld[b]) || (mld[i] == mld[b] && mage[i] > mage[b])) b = i;
      if (b >= 0 && unit_ready[c] && !mbusy[c] && ngr < int'(preg_avail)) begin
        ev[c] = 1; ed[c*TW +: TW] = mdst[b]; es[c*SW +: SW] = SW'(b);
        tk[b] = 1; ngr++;
      end
    end
    chk({tag, " grant"}, 64'(dsp_valid), 64'(ev));
    chk({tag, " dst"}, 64'(dsp_dst), 64'(ed));
    chk({tag, " slot"}, 64'(dsp_slot), 64'(es));
    chk({tag, " full"}, 64'(full), 64'(efull));
    fi = -1;
    for (int i = D - 1; i >= 0; i--) if (!mv[i]) fi = i;
    go = enq_valid && !efull && !flush;
    mbusy = (mbusy & ~unit_done) | (ev & ~PM);
    if (flush) begin
      for (int i = 0; i < D; i++) mv[i] = 0;
    end else begin
      for (int i = 0; i < D; i++) begin
        if (tk[i]) mv[i] = 0;
        else if (mv[i]) begin
          mr0[i] = mr0[i] | mwoke(ms0[i]);
          mr1[i] = mr1[i] | mwoke(ms1[i]);
          if (mage[i] < 7) mage[i]++;
        end
      end
      if (go) begin
        mv[fi] = 1; ms0[fi] = enq_src0; ms1[fi] = enq_src1; mdst[fi] = enq_dst;
        mr0[fi] = enq_rdy0 | mwoke(enq_src0); mr1[fi] = enq_rdy1 | mwoke(enq_src1);
        mcls[fi] = enq_cls; mld[fi] = enq_load; mage[fi] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(logic [TW-1:0] a, bit ra, logic [TW-1:0] b, bit rb,
                     logic [TW-1:0] d, logic [1:0] c, bit l);
    enq_valid = 1; enq_src0 = a; enq_rdy0 = ra; enq_src1 = b; enq_rdy1 = rb;
    enq_dst = d; enq_cls = c; enq_load = l;
  endtask

  task automatic flush_q();
    enq_valid = 0; wk_valid = 0; unit_done = 0;
    flush = 1; cyc("R9");
    flush = 0;
    #1 chk("R9 no grant after flush", 64'(dsp_valid), 0);
    chk("R9 not full after flush", 64'(full), 0);
  endtask

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) begin mv[i] = 0; mage[i] = 0; mcls[i] = 0; end
    @(negedge clk); @(negedge clk);
    #1 chk("R10 reset full", 64'(full), 0);
    chk("R10 reset grant", 64'(dsp_valid), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 and R6: waiting older entry, ready younger entry
    flush_q();
    put(6'd5, 0, 6'd1, 1, 6'h21, 0, 0); cyc("R1");
    put(6'd2, 1, 6'd3, 1, 6'h22, 0, 0);
    #1 chk("R1 unready not granted", 64'(dsp_valid[0]), 0);
    cyc("R1");
    enq_valid = 0; wk_valid = 2'b01; wk_tag = {6'd0, 6'd5};
    #1 chk("R6 younger first", 64'(dsp_valid[0]), 1);
    chk("R6 younger slot", 64'(dsp_slot[2:0]), 1);
    cyc("R6");
    wk_valid = 0;
    #1 chk("R1 woken next cycle", 64'(dsp_slot[2:0]), 0);
    chk("R1 woken dst", 64'(dsp_dst[5:0]), 64'h21);
    cyc("R1");

    // R4: load beats older non-load
    flush_q();
    unit_ready = 4'b1101;
    put(6'd1, 1, 6'd1, 1, 6'h31, 1, 0); cyc("R4");
    put(6'd1, 1, 6'd1, 1, 6'h32, 1, 1); cyc("R4");
    enq_valid = 0; cyc("R4");
    unit_ready = '1;
    #1 chk("R4 load chosen", 64'(dsp_slot[5:3]), 1);
    cyc("R4");

    // R5: older wins among non-loads
    flush_q();
    unit_ready = 4'b1101;
    put(6'd1, 1, 6'd1, 1, 6'h11, 1, 0); cyc("R5");
    put(6'd1, 1, 6'd1, 1, 6'h12, 1, 0); cyc("R5");
    enq_valid = 0; unit_ready = '1;
    #1 chk("R5 older first", 64'(dsp_slot[5:3]), 0);
    cyc("R5");
    #1 chk("R5 younger next", 64'(dsp_slot[5:3]), 1);
    cyc("R5");

    // R7: unpipelined class 3, pipelined class 0
    flush_q();
    unit_ready = 4'b0110;
    put(6'd1, 1, 6'd1, 1, 6'h01, 3, 0); cyc("R7");
    put(6'd1, 1, 6'd1, 1, 6'h02, 3, 0); cyc("R7");
    for (int i = 0; i < 3; i++) begin put(6'd1, 1, 6'd1, 1, 6'(8 + i), 0, 0); cyc("R7"); end
    enq_valid = 0; unit_ready = '1;
    #1 chk("R7 divider first", 64'(dsp_valid), 4'b1001);
    cyc("R7");
    #1 chk("R7 divider busy, pipe again", 64'(dsp_valid), 4'b0001);
    cyc("R7");
    unit_done = 4'b1000;
    #1 chk("R7 busy in done cycle", 64'(dsp_valid), 4'b0001);
    cyc("R7");
    unit_done = 0;
    #1 chk("R7 after done", 64'(dsp_valid), 4'b1000);
    cyc("R7");
    unit_done = 4'b1000; cyc("R7"); unit_done = 0;

    // R3: rename register shortage
    flush_q();
    unit_ready = 0;
    put(6'd1, 1, 6'd1, 1, 6'h05, 0, 0); cyc("R3");
    put(6'd1, 1, 6'd1, 1, 6'h06, 2, 0); cyc("R3");
    put(6'd1, 1, 6'd1, 1, 6'h07, 1, 0); cyc("R3");
    enq_valid = 0; unit_ready = '1; preg_avail = 1;
    #1 chk("R3 one register", 64'(dsp_valid), 4'b0001);
    cyc("R3");
    preg_avail = 0;
    #1 chk("R3 no register", 64'(dsp_valid), 0);
    cyc("R3");
    preg_avail = 2;
    #1 chk("R3 two registers", 64'(dsp_valid), 4'b0110);
    cyc("R3");
    preg_avail = 4;

    // R8: full queue drops enqueue
    flush_q();
    for (int i = 0; i < D; i++) begin put(6'd40, 0, 6'd1, 1, 6'(16 + i), 2, 0); cyc("R8"); end
    #1 chk("R8 full", 64'(full), 1);
    put(6'd1, 1, 6'd1, 1, 6'h3f, 0, 0); cyc("R8");
    enq_valid = 0;
    #1 chk("R8 dropped entry absent", 64'(dsp_valid), 0);
    cyc("R8");
    wk_valid = 2'b10; wk_tag = {6'd40, 6'd0}; cyc("R8");
    wk_valid = 0;
    #1 chk("R8 first slot out", 64'(dsp_slot[8:6]), 0);
    cyc("R8");
    #1 chk("R8 not full after dispatch", 64'(full), 0);
    cyc("R8");

    // random mix
    flush_q();
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      enq_valid = ($urandom % 4) != 0;
      enq_src0 = 6'($urandom % 16); enq_rdy0 = ($urandom % 3) == 0;
      enq_src1 = 6'($urandom % 16); enq_rdy1 = ($urandom % 2) == 0;
      enq_dst = 6'($urandom); enq_cls = 2'($urandom); enq_load = ($urandom % 4) == 0;
      wk_valid = 2'($urandom);
      wk_tag = {6'($urandom % 16), 6'($urandom % 16)};
      unit_ready = 4'($urandom | $urandom);
      unit_done = ($urandom % 4 == 0) ? 4'b1000 : 4'b0000;
      preg_avail = 3'($urandom % 5);
      flush = ($urandom % 64) == 0;
      cyc("R2 R4 R5 random");
    end
    flush = 0; enq_valid = 0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule